// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block receives a stereo audio stream as a clocked slave. The bit clock, the left/right word clock and the serial data line all come from an external transmitter. They are brought into the system clock domain, and the data is sampled on the active bit-clock edge. Each channel word is deserialized and presented on two 32-bit parallel outputs, sign-extended from the configured word length. A one-cycle strobe marks every completed stereo pair.

A seven-bit configuration register selects how the stream is decoded:
- the frame alignment: right-justified, left-justified, I2S or a pulse-framed DSP layout;
- the word length;
- which bit-clock edge is active;
- the word-clock polarity, or the MSB offset in DSP layout;
- whether the two channels are exchanged.

One combination cannot be decoded: right-justified alignment with 32-bit words. The block flags it and freezes its outputs while it is selected.

Top module: `arx_rx`

## Requirements
- R1: After reset the configuration selects I2S with 24-bit words, with no swap, no polarity inversion and rising-edge sampling. The outputs are zero, and `smp_valid` and `cfg_err` are low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration. The fields are:
  - bits [1:0], alignment: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP;
  - bits [3:2], word length: 00 16, 01 20, 10 24, 11 32;
  - bit 4, word-clock polarity invert, or DSP offset select;
  - bit 5, channel swap;
  - bit 6, falling-edge sampling.
- R3: In I2S alignment the MSB is taken on the second active edge after a word-clock transition. A low word clock is the left channel; bit 4 inverts this.
- R4: In left-justified alignment the MSB is taken on the first active edge after a transition. A high word clock is the left channel; bit 4 inverts this.
- R5: In right-justified alignment the word is the last N bits received before the next word-clock transition. The half-frame that ends at that transition gives the channel: high is left, and bit 4 inverts this.
- R6: In DSP alignment a rising word clock starts a frame. The left word is followed directly by the right word. With bit 4 set the MSB is on the first active edge after the rise; with bit 4 clear it is on the second. No polarity inversion applies.
- R7: Each word of N bits appears on its output sign-extended from bit N-1 to 32 bits.
- R8: With swap set, the word received in the left slot is output on `smp_right`, and the word received in the right slot is output on `smp_left`.
- R9: With bit 6 set, data and word clock are sampled on the falling bit-clock edge instead of the rising edge.
- R10: `smp_valid` pulses for exactly one cycle when a right-slot word completes after a left-slot word of the same frame. Both outputs update in that same cycle.
- R11: Right-justified alignment with 32-bit words drives `cfg_err` high. While it is selected, no strobe is issued and both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration value (fields in R2) |
| bclk | input | 1 | Serial bit clock from the transmitter |
| lrclk | input | 1 | Word clock / frame pulse from the transmitter |
| sdin | input | 1 | Serial data |
| smp_left | output | 32 | Left sample, sign-extended |
| smp_right | output | 32 | Right sample, sign-extended |
| smp_valid | output | 1 | One-cycle strobe for a new stereo pair |
| cfg_err | output | 1 | Unsupported configuration selected |

## Verification
The bench uses the default two-stage input synchronizer and drives the bit clock at one eighth of the system clock, so every bit-clock phase lasts four system cycles. This leaves room for the synchronizer and edge detector on both bit-clock senses. Each half-frame is 34 bit clocks and each DSP frame is 66, so both the I2S one-bit delay and DSP mode A fit a full 32-bit word. The bit counter is derived from the 32-bit sample width and never saturates inside these frames, so every word length can be reached in every alignment that accepts it.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;

  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    WL_16 = 2'b00,
    WL_20 = 2'b01,
    WL_24 = 2'b10,
    WL_32 = 2'b11
  } wlen_e;

  typedef struct packed {
    logic  fall_edge;
    logic  swap;
    logic  pol;
    wlen_e wlen;
    fmt_e  fmt;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{fall_edge: 1'b0, swap: 1'b0, pol: 1'b0,
                                 wlen: WL_24, fmt: FMT_I2S};

  function automatic int unsigned wlen_bits(input wlen_e wl);
    case (wl)
      WL_16:   return 16;
      WL_20:   return 20;
      WL_24:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] sign_ext(input logic [SAMPLE_W-1:0] raw,
                                                   input wlen_e wl);
    case (wl)
      WL_16:   return {{16{raw[15]}}, raw[15:0]};
      WL_20:   return {{12{raw[19]}}, raw[19:0]};
      WL_24:   return {{8{raw[23]}}, raw[23:0]};
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/arx_sync.sv
`timescale 1ns/1ps
module arx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/arx_front.sv
`timescale 1ns/1ps
module arx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdin,
  input  logic fall_edge,
  output logic edge_stb,
  output logic lr_smp,
  output logic sd_smp
);

  logic [2:0] sync_q;
  logic       bclk_d_q;
  logic       bclk_s;

  arx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bclk, lrclk, sdin}),
    .q    (sync_q)
  );

  assign bclk_s = sync_q[2];
  assign lr_smp = sync_q[1];
  assign sd_smp = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d_q <= 1'b0;
    else        bclk_d_q <= bclk_s;
  end

  always_comb begin
    if (fall_edge) edge_stb = bclk_d_q & ~bclk_s;
    else           edge_stb = ~bclk_d_q & bclk_s;
  end

endmodule

// File: rtl/arx_deser.sv
`timescale 1ns/1ps
module arx_deser
  import arx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_stb,
  input  logic                lr_in,
  input  logic                sd_in,
  input  fmt_e                fmt,
  input  wlen_e               wlen,
  input  logic                pol,
  input  logic                hold,
  output logic                slot_done,
  output logic                slot_is_left,
  output logic [SAMPLE_W-1:0] slot_word
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                lr_prev_q, primed_q, framed_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] sh_q;
  logic                done_q, left_q;
  logic [SAMPLE_W-1:0] word_q;

  logic                is_dsp, boundary;
  logic [CNT_W-1:0]    cnt_nx, nbits, off, first_end, second_end;
  logic [SAMPLE_W-1:0] sh_nx, raw, word_nx;
  logic                lr_eff, lr_prev_eff, done_nx, left_nx;

  always_comb begin
    is_dsp      = (fmt == FMT_DSP);
    boundary    = primed_q && (is_dsp ? (lr_in & ~lr_prev_q) : (lr_in ^ lr_prev_q));
    cnt_nx      = boundary ? '0 : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1);
    sh_nx       = {sh_q[SAMPLE_W-2:0], sd_in};
    nbits       = CNT_W'(wlen_bits(wlen));
    off         = ((fmt == FMT_I2S) || (is_dsp && !pol)) ? CNT_W'(1) : '0;
    first_end   = off + nbits - CNT_W'(1);
    second_end  = first_end + nbits;
    lr_eff      = lr_in ^ pol;
    lr_prev_eff = lr_prev_q ^ pol;
    done_nx     = 1'b0;
    left_nx     = 1'b0;
    raw         = sh_nx;
    case (fmt)
      FMT_RJ: begin
        done_nx = boundary && framed_q;
        left_nx = lr_prev_eff;
        raw     = sh_q;
      end
      FMT_LJ: begin
        done_nx = (cnt_nx == first_end);
        left_nx = lr_eff;
      end
      FMT_I2S: begin
        done_nx = (cnt_nx == first_end);
        left_nx = ~lr_eff;
      end
      default: begin
        if (cnt_nx == first_end) begin
          done_nx = 1'b1;
          left_nx = 1'b1;
        end else if (cnt_nx == second_end) begin
          done_nx = 1'b1;
          left_nx = 1'b0;
        end
      end
    endcase
    word_nx = sign_ext(raw, wlen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      framed_q  <= 1'b0;
      cnt_q     <= CNT_MAX;
      sh_q      <= '0;
      done_q    <= 1'b0;
      left_q    <= 1'b0;
      word_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (edge_stb) begin
        lr_prev_q <= lr_in;
        primed_q  <= 1'b1;
        if (boundary) framed_q <= 1'b1;
        cnt_q     <= cnt_nx;
        sh_q      <= sh_nx;
        done_q    <= done_nx & ~hold;
        left_q    <= left_nx;
        word_q    <= word_nx;
      end
    end
  end

  assign slot_done    = done_q;
  assign slot_is_left = left_q;
  assign slot_word    = word_q;

endmodule

// File: rtl/arx_out.sv
`timescale 1ns/1ps
module arx_out
  import arx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_done,
  input  logic                slot_is_left,
  input  logic [SAMPLE_W-1:0] slot_word,
  input  logic                swap,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                out_valid
);

  logic [SAMPLE_W-1:0] hold_q, hold_nx;
  logic                have_q, have_nx;
  logic [SAMPLE_W-1:0] l_q, l_nx, r_q, r_nx;
  logic                v_q, v_nx;

  always_comb begin
    hold_nx = hold_q;
    have_nx = have_q;
    l_nx    = l_q;
    r_nx    = r_q;
    v_nx    = 1'b0;
    if (slot_done) begin
      if (slot_is_left) begin
        hold_nx = slot_word;
        have_nx = 1'b1;
      end else if (have_q) begin
        l_nx    = swap ? slot_word : hold_q;
        r_nx    = swap ? hold_q : slot_word;
        v_nx    = 1'b1;
        have_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      have_q <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
      v_q    <= 1'b0;
    end else begin
      hold_q <= hold_nx;
      have_q <= have_nx;
      l_q    <= l_nx;
      r_q    <= r_nx;
      v_q    <= v_nx;
    end
  end

  assign out_left  = l_q;
  assign out_right = r_q;
  assign out_valid = v_q;

endmodule

// File: rtl/arx_rx.sv
`timescale 1ns/1ps
module arx_rx
  import arx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [6:0]  cfg_wdata,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdin,
  output logic [31:0] smp_left,
  output logic [31:0] smp_right,
  output logic        smp_valid,
  output logic        cfg_err
);

  localparam int CNT_W = $clog2(2 * SAMPLE_W + 2) + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  cfg_t       cfg_q, cfg_nx;

  logic                edge_stb, lr_smp, sd_smp;
  logic                slot_done, slot_is_left;
  logic [SAMPLE_W-1:0] slot_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    cfg_nx = cfg_q;
    if (cfg_we) cfg_nx = cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= CFG_RESET;
    else             cfg_q <= cfg_nx;
  end

  assign cfg_err = (cfg_q.fmt == FMT_RJ) && (cfg_q.wlen == WL_32);

  arx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bclk     (bclk),
    .lrclk    (lrclk),
    .sdin     (sdin),
    .fall_edge(cfg_q.fall_edge),
    .edge_stb (edge_stb),
    .lr_smp   (lr_smp),
    .sd_smp   (sd_smp)
  );

  arx_deser #(.CNT_W(CNT_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .edge_stb    (edge_stb),
    .lr_in       (lr_smp),
    .sd_in       (sd_smp),
    .fmt         (cfg_q.fmt),
    .wlen        (cfg_q.wlen),
    .pol         (cfg_q.pol),
    .hold        (cfg_err),
    .slot_done   (slot_done),
    .slot_is_left(slot_is_left),
    .slot_word   (slot_word)
  );

  arx_out u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .slot_done   (slot_done),
    .slot_is_left(slot_is_left),
    .slot_word   (slot_word),
    .swap        (cfg_q.swap),
    .out_left    (smp_left),
    .out_right   (smp_right),
    .out_valid   (smp_valid)
  );

endmodule

// File: rtl/arx_rx_checker.sv
`timescale 1ns/1ps
module arx_rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_wdata,
  input logic [1:0]  wlen,
  input logic        swap,
  input logic        cfg_err,
  input logic        slot_done,
  input logic        slot_is_left,
  input logic [31:0] slot_word,
  input logic        smp_valid,
  input logic [31:0] smp_left,
  input logic [31:0] smp_right
);

  // R10: strobe is a single cycle wide
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R10: strobe only follows a completed right-slot word
  p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(slot_done) && !$past(slot_is_left)));

  // R11: error flag follows the written fields
  p_cfg_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_err == (($past(cfg_wdata[1:0]) == 2'b00) && ($past(cfg_wdata[3:2]) == 2'b11))));

  // R11: outputs frozen once the error has settled through the pipeline
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err) && $past(cfg_err, 2)) |->
      (!smp_valid && $stable(smp_left) && $stable(smp_right)));

  // R8: right output carries the right-slot word when not swapped
  p_swap_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !$past(swap)) |-> (smp_right == $past(slot_word)));

  // R8: left output carries the right-slot word when swapped
  p_swap_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(swap)) |-> (smp_left == $past(slot_word)));

  // R7: 16-bit words leave the engine sign-extended
  p_sext16_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && ($past(wlen) == 2'b00)) |-> (slot_word[31:16] == {16{slot_word[15]}}));

endmodule

bind arx_rx arx_rx_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata[3:0]),
  .wlen        (cfg_q.wlen),
  .swap        (cfg_q.swap),
  .cfg_err     (cfg_err),
  .slot_done   (slot_done),
  .slot_is_left(slot_is_left),
  .slot_word   (slot_word),
  .smp_valid   (smp_valid),
  .smp_left    (smp_left),
  .smp_right   (smp_right)
);

// File: tb/test_arx_rx.sv
`timescale 1ns/1ps
module test_arx_rx;

  localparam int HP = 4;   // system cycles per bit-clock phase
  localparam int SW = 34;  // bit clocks per half-frame
  localparam int DF = 66;  // bit clocks per DSP frame

  typedef struct packed {
    logic [6:0]  cfg;
    logic [31:0] l;
    logic [31:0] r;
    logic [31:0] el;
    logic [31:0] er;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{7'h0A, 32'h00A5C3E1, 32'h00123456, 32'hFFA5C3E1, 32'h00123456},
    '{7'h01, 32'h00008001, 32'h00007FFE, 32'hFFFF8001, 32'h00007FFE},
    '{7'h04, 32'h000ABCDE, 32'h00054321, 32'hFFFABCDE, 32'h00054321},
    '{7'h0F, 32'h80000001, 32'h7FFFFFFF, 32'h80000001, 32'h7FFFFFFF},
    '{7'h1B, 32'h00400000, 32'h00800000, 32'h00400000, 32'hFF800000},
    '{7'h32, 32'h00001234, 32'h0000FEDC, 32'hFFFFFEDC, 32'h00001234},
    '{7'h4D, 32'hDEADBEEF, 32'h0BADF00D, 32'hDEADBEEF, 32'h0BADF00D},
    '{7'h18, 32'h00C00001, 32'h003FFFFE, 32'hFFC00001, 32'h003FFFFE},
    '{7'h25, 32'h00012345, 32'h000F0000, 32'hFFFF0000, 32'h00012345}
  };

  logic        clk, rst_n, cfg_we, bclk, lrclk, sdin;
  logic [6:0]  cfg_wdata;
  logic [31:0] smp_left, smp_right;
  logic        smp_valid, cfg_err;

  int n_chk, n_fail;
  int mon_cnt, mon_wide;
  logic [31:0] mon_l, mon_r;
  logic        mon_prev;

  arx_rx i_arx_rx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    mon_cnt = 0; mon_wide = 0; mon_prev = 1'b0; mon_l = '0; mon_r = '0;
  end

  always @(negedge clk) begin
    if (smp_valid) begin
      mon_cnt = mon_cnt + 1;
      mon_l   = smp_left;
      mon_r   = smp_right;
      if (mon_prev) mon_wide = mon_wide + 1;
    end
    mon_prev = smp_valid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  function automatic string tag(input logic [6:0] c);
    string s;
    case (c[1:0])
      2'b00:   s = "R5";
      2'b01:   s = "R4";
      2'b10:   s = "R3";
      default: s = "R6";
    endcase
    if (c[5]) s = {s, "+R8"};
    if (c[6]) s = {s, "+R9"};
    return {s, "+R2"};
  endfunction

  function automatic logic tx_bit(input logic [1:0] fmt, input int k, input int n,
                                  input logic [31:0] v);
    case (fmt)
      2'b01:   return (k < n) ? v[n-1-k] : 1'b0;
      2'b10:   return (k >= 1 && k <= n) ? v[n-k] : 1'b0;
      default: return (k >= SW - n) ? v[SW-1-k] : 1'b0;
    endcase
  endfunction

  task automatic do_reset(input logic idle_bclk);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    bclk = idle_bclk; lrclk = 1'b0; sdin = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [6:0] c);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = c;
    @(posedge clk); #1 cfg_we = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic tick(input logic lr, input logic d, input logic inv);
    lrclk = lr; sdin = d;
    repeat (HP) @(posedge clk); #1 bclk = ~inv;
    repeat (HP) @(posedge clk); #1 bclk = inv;
  endtask

  task automatic run_stream(input logic [6:0] c, input logic [31:0] l, input logic [31:0] r);
    logic [1:0] fmt;
    logic inv, pol, left_lvl;
    int n, off;
    fmt = c[1:0]; pol = c[4]; inv = c[6];
    n = (c[3:2] == 2'b00) ? 16 : (c[3:2] == 2'b01) ? 20 : (c[3:2] == 2'b10) ? 24 : 32;
    bclk = inv;
    repeat (4) @(posedge clk); #1;
    if (fmt == 2'b11) begin
      off = pol ? 0 : 1;
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, inv);
      for (int f = 0; f < 3; f++) begin
        for (int k = 0; k < DF; k++) begin
          logic d;
          d = 1'b0;
          if (k >= off && k < off + n) d = l[n-1-(k-off)];
          else if (k >= off + n && k < off + 2*n) d = r[n-1-(k-off-n)];
          tick(k == 0, d, inv);
        end
      end
      for (int i = 0; i < 2; i++) tick(1'b0, 1'b0, inv);
    end else begin
      left_lvl = ((fmt == 2'b10) ? 1'b0 : 1'b1) ^ pol;
      for (int i = 0; i < 4; i++) tick(~left_lvl, 1'b0, inv);
      for (int f = 0; f < 3; f++) begin
        for (int k = 0; k < SW; k++) tick(left_lvl, tx_bit(fmt, k, n, l), inv);
        for (int k = 0; k < SW; k++) tick(~left_lvl, tx_bit(fmt, k, n, r), inv);
      end
      for (int i = 0; i < 2; i++) tick(left_lvl, 1'b0, inv);
    end
    repeat (12) @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int base;
    n_chk = 0; n_fail = 0;

    // R1: reset state at the ports
    do_reset(1'b0);
    chk("R1 left after reset", smp_left, 32'h0);
    chk("R1 right after reset", smp_right, 32'h0);
    chk("R1 valid after reset", {31'h0, smp_valid}, 32'h0);
    chk("R1 cfg_err after reset", {31'h0, cfg_err}, 32'h0);

    // R1: default configuration decodes I2S 24-bit without any write
    base = mon_cnt;
    run_stream(7'h0A, VECS[0].l, VECS[0].r);
    chk("R1 default cfg pair count", 32'(mon_cnt - base), 32'd3);
    chk("R1 default cfg left", mon_l, VECS[0].el);
    chk("R1 default cfg right", mon_r, VECS[0].er);

    // table walk: formats, word lengths, polarity, swap, edge sense
    for (int v = 0; v < 9; v++) begin
      do_reset(VECS[v].cfg[6]);
      write_cfg(VECS[v].cfg);
      base = mon_cnt;
      run_stream(VECS[v].cfg, VECS[v].l, VECS[v].r);
      chk({tag(VECS[v].cfg), "+R10 pair count"}, 32'(mon_cnt - base), 32'd3);
      chk({tag(VECS[v].cfg), "+R7 left"}, mon_l, VECS[v].el);
      chk({tag(VECS[v].cfg), "+R7 right"}, mon_r, VECS[v].er);
    end

    // R11: unsupported combination holds the outputs
    do_reset(1'b0);
    write_cfg(7'h0A);
    run_stream(7'h0A, VECS[0].l, VECS[0].r);
    write_cfg(7'h0C);
    chk("R11 cfg_err raised", {31'h0, cfg_err}, 32'h1);
    base = mon_cnt;
    run_stream(7'h0C, 32'h11111111, 32'h22222222);
    chk("R11 no strobe while in error", 32'(mon_cnt - base), 32'd0);
    chk("R11 left held", smp_left, VECS[0].el);
    chk("R11 right held", smp_right, VECS[0].er);
    write_cfg(7'h08);
    chk("R11 cfg_err cleared", {31'h0, cfg_err}, 32'h0);

    // R10: every strobe seen was one cycle wide
    chk("R10 strobe width", 32'(mon_wide), 32'd0);

    summary();
    $finish;
  end

endmodule